// File: doc/BRIEF.md
# Memory-Reference Instruction Decode Unit

This unit decodes 16-bit instruction words for a small accumulator machine. For each word it works out which operation the word names. In the execute phase it raises one strobe for that operation. The decoded operations are the six memory-reference operations (load, store, add, subtract, jump, increment-and-skip-if-zero) and four non-memory operations (load-immediate, skip-if-accumulator-zero, halt, clear-accumulator-and-link). A word that matches no known pattern raises an illegal-instruction flag instead of a strobe.

The most critical output is the memory-buffer increment request. Memory control uses it to add one to the word held in the memory buffer before the word is written back. The request may come from only two sources:
- the execute phase of an increment-and-skip instruction;
- the defer (pointer fetch) phase of an indirect memory reference whose pointer lies in the auto-increment window (octal 10 to 17).

Any other access that reads or writes memory must leave the contents unchanged. The unit also produces a skip output, which tells the sequencer to advance the program counter by two rather than one. All outputs are registered on the clock edge that ends the phase. The surrounding sequencer supplies the current phase, the address of the fetched pointer, the memory word being operated on and an accumulator-zero flag.

Top module: `mrd_decode`

## Requirements
- R1: With phase code 2 (execute), the word's bits 14:12 select the memory-reference operation. Value 1 is jump, 2 is store, 3 is increment-and-skip and 7 is subtract, whatever bit 11 is. Value 6 is load when bit 11 is 0 and add when bit 11 is 1. Bit 15 (indirect) does not change the operation.
- R2: In execute, the exact words 000000 (halt), 002001 (skip-if-accumulator-zero) and 100011 (clear-accumulator-and-link), all octal, each raise their own strobe.
- R3: In execute, a word with bits 15:11 equal to 00001 is load-immediate. `imm_o` then carries bits 10:0 of the word, zero-extended; in every other case `imm_o` is zero.
- R4: In execute, any other word raises `illegal_o` and no strobe. This covers bits 14:12 equal to 4 or 5, load-immediate with bit 15 set, and a word with bits 14:11 zero that is not one of the three exact words. `illegal_o` stays low outside execute.
- R5: `exec_stb_o` is zero-or-one-hot and is nonzero only in the cycle after an execute-phase edge. The bit positions are: 0 load, 1 store, 2 add, 3 subtract, 4 jump, 5 increment-and-skip, 6 load-immediate, 7 skip-if-accumulator-zero, 8 halt, 9 clear. Phase codes: 0 fetch, 1 defer, 2 execute, 3 idle.
- R6: `mb_inc_req_o` asserts after every execute-phase edge of an increment-and-skip word, whether the word is direct or indirect.
- R7: `mb_inc_req_o` asserts after a defer-phase edge when the word is a memory reference (bits 14:12 in {1,2,3,6,7}), bit 15 is set, and `ptr_addr_i` lies in 8..15 (octal 10..17).
- R8: `mb_inc_req_o` stays low in all other cases. These include direct references in any phase, indirect references whose pointer lies outside 8..15, non-memory words with bit 15 set, and the fetch and idle phases.
- R9: `skip_o` asserts after an execute edge of increment-and-skip when `mem_word_i` is all ones, so that the incremented value wraps to zero.
- R10: `skip_o` asserts after an execute edge of skip-if-accumulator-zero when `acc_zero_i` is high, and in no other case.
- R11: While `rst` is high at a clock edge, every output becomes zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word |
| phase_i | input | 2 | Current phase: 0 fetch, 1 defer, 2 execute, 3 idle |
| ptr_addr_i | input | 16 | Address of the pointer word fetched in defer |
| mem_word_i | input | 16 | Memory buffer word before any increment |
| acc_zero_i | input | 1 | Accumulator equals zero |
| exec_stb_o | output | 10 | One-hot execute strobes (positions in R5) |
| mb_inc_req_o | output | 1 | Memory-buffer increment request |
| skip_o | output | 1 | Advance program counter by two |
| illegal_o | output | 1 | Unrecognised word in execute |
| imm_o | output | 16 | Load-immediate value |

## Verification
A stuck or wrongly gated increment path does not stop the program. It shows at the ports as `mb_inc_req_o` high one cycle after an ordinary load, store, add or jump edge. In memory it would silently add one to every word touched. For this reason, direct references, pointers just outside the window (octal 7 and 20), and indirect-flagged non-memory words are all driven in the defer and execute phases. A decode fault in bits 14:11 shows one cycle later as a wrong strobe bit, as a missing strobe, or as a false `illegal_o`.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_DEFER = 2'd1,
    PH_EXEC  = 2'd2,
    PH_IDLE  = 2'd3
  } phase_e;

  localparam int NOPS   = 10;
  localparam int OP_LAC = 0;
  localparam int OP_DAC = 1;
  localparam int OP_ADD = 2;
  localparam int OP_SUB = 3;
  localparam int OP_JMP = 4;
  localparam int OP_ISZ = 5;
  localparam int OP_LAW = 6;
  localparam int OP_ASZ = 7;
  localparam int OP_HLT = 8;
  localparam int OP_CAL = 9;

  localparam logic [2:0] MJ_JMP = 3'd1;
  localparam logic [2:0] MJ_DAC = 3'd2;
  localparam logic [2:0] MJ_ISZ = 3'd3;
  localparam logic [2:0] MJ_LD  = 3'd6;
  localparam logic [2:0] MJ_SUB = 3'd7;

  localparam logic [15:0] WORD_HLT = 16'o000000;
  localparam logic [15:0] WORD_ASZ = 16'o002001;
  localparam logic [15:0] WORD_CAL = 16'o100011;

endpackage

// File: rtl/mrd_field_decode.sv
module mrd_field_decode
  import mrd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] instr,
  output logic [NOPS-1:0]   op_hit,
  output logic              is_memref,
  output logic              indirect,
  output logic              bad_pat,
  output logic [WORD_W-1:0] imm_raw
);
  localparam int IND_B  = WORD_W - 1;
  localparam int MJ_HI  = WORD_W - 2;
  localparam int MJ_LO  = WORD_W - 4;
  localparam int MIN_B  = WORD_W - 5;
  localparam int IMM_W  = WORD_W - 5;

  logic [2:0] major;
  logic       minor;

  assign major    = instr[MJ_HI:MJ_LO];
  assign minor    = instr[MIN_B];
  assign indirect = instr[IND_B];
  assign imm_raw  = {{(WORD_W-IMM_W){1'b0}}, instr[IMM_W-1:0]};

  always_comb begin
    op_hit    = '0;
    is_memref = 1'b0;
    bad_pat   = 1'b0;
    case (major)
      MJ_JMP: begin op_hit[OP_JMP] = 1'b1; is_memref = 1'b1; end
      MJ_DAC: begin op_hit[OP_DAC] = 1'b1; is_memref = 1'b1; end
      MJ_ISZ: begin op_hit[OP_ISZ] = 1'b1; is_memref = 1'b1; end
      MJ_SUB: begin op_hit[OP_SUB] = 1'b1; is_memref = 1'b1; end
      MJ_LD: begin
        is_memref = 1'b1;
        if (minor) op_hit[OP_ADD] = 1'b1;
        else       op_hit[OP_LAC] = 1'b1;
      end
      3'd0: begin
        if (minor) begin
          if (!indirect) op_hit[OP_LAW] = 1'b1;
          else           bad_pat = 1'b1;
        end else if (instr == WORD_W'(WORD_HLT)) begin
          op_hit[OP_HLT] = 1'b1;
        end else if (instr == WORD_W'(WORD_ASZ)) begin
          op_hit[OP_ASZ] = 1'b1;
        end else if (instr == WORD_W'(WORD_CAL)) begin
          op_hit[OP_CAL] = 1'b1;
        end else begin
          bad_pat = 1'b1;
        end
      end
      default: bad_pat = 1'b1;
    endcase
  end

endmodule

// File: rtl/mrd_incr_gate.sv
module mrd_incr_gate
  import mrd_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int AUTO_BASE  = 8,
  parameter int AUTO_COUNT = 8
) (
  input  logic [1:0]        phase,
  input  logic              isz_hit,
  input  logic              is_memref,
  input  logic              indirect,
  input  logic [WORD_W-1:0] ptr_addr,
  output logic              inc_req
);
  localparam int              LOG_N  = $clog2(AUTO_COUNT);
  localparam logic [WORD_W-1:0] BASE_V = WORD_W'(AUTO_BASE);
  localparam logic [WORD_W-1:0] LAST_V = WORD_W'(AUTO_BASE + AUTO_COUNT - 1);
  localparam bool_aligned = ((AUTO_COUNT & (AUTO_COUNT - 1)) == 0) &&
                            ((AUTO_BASE % AUTO_COUNT) == 0) && (LOG_N > 0);

  logic in_window;

  generate
    if (bool_aligned) begin : g_mask
      assign in_window = (ptr_addr[WORD_W-1:LOG_N] == BASE_V[WORD_W-1:LOG_N]);
    end else begin : g_range
      assign in_window = (ptr_addr >= BASE_V) && (ptr_addr <= LAST_V);
    end
  endgenerate

  logic from_exec;
  logic from_defer;

  assign from_exec  = (phase == PH_EXEC) && isz_hit;
  assign from_defer = (phase == PH_DEFER) && is_memref && indirect && in_window;
  assign inc_req    = from_exec || from_defer;

endmodule

// File: rtl/mrd_out_reg.sv
module mrd_out_reg
  import mrd_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NOPS-1:0]   stb_d,
  input  logic              inc_d,
  input  logic              skip_d,
  input  logic              ill_d,
  input  logic [WORD_W-1:0] imm_d,
  output logic [NOPS-1:0]   stb_q,
  output logic              inc_q,
  output logic              skip_q,
  output logic              ill_q,
  output logic [WORD_W-1:0] imm_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q  <= '0;
      inc_q  <= 1'b0;
      skip_q <= 1'b0;
      ill_q  <= 1'b0;
      imm_q  <= '0;
    end else begin
      stb_q  <= stb_d;
      inc_q  <= inc_d;
      skip_q <= skip_d;
      ill_q  <= ill_d;
      imm_q  <= imm_d;
    end
  end
endmodule

// File: rtl/mrd_decode.sv
module mrd_decode
  import mrd_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int AUTO_BASE  = 8,
  parameter int AUTO_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [1:0]        phase_i,
  input  logic [WORD_W-1:0] ptr_addr_i,
  input  logic [WORD_W-1:0] mem_word_i,
  input  logic              acc_zero_i,
  output logic [NOPS-1:0]   exec_stb_o,
  output logic              mb_inc_req_o,
  output logic              skip_o,
  output logic              illegal_o,
  output logic [WORD_W-1:0] imm_o
);
  logic [NOPS-1:0]   op_hit;
  logic              is_memref;
  logic              indirect;
  logic              bad_pat;
  logic [WORD_W-1:0] imm_raw;
  logic              inc_d;
  logic              in_exec;
  logic              wraps;
  logic [NOPS-1:0]   stb_d;
  logic              skip_d;
  logic              ill_d;
  logic [WORD_W-1:0] imm_d;

  mrd_field_decode #(.WORD_W(WORD_W)) u_fdec (
    .instr     (instr_i),
    .op_hit    (op_hit),
    .is_memref (is_memref),
    .indirect  (indirect),
    .bad_pat   (bad_pat),
    .imm_raw   (imm_raw)
  );

  mrd_incr_gate #(
    .WORD_W     (WORD_W),
    .AUTO_BASE  (AUTO_BASE),
    .AUTO_COUNT (AUTO_COUNT)
  ) u_incg (
    .phase     (phase_i),
    .isz_hit   (op_hit[OP_ISZ]),
    .is_memref (is_memref),
    .indirect  (indirect),
    .ptr_addr  (ptr_addr_i),
    .inc_req   (inc_d)
  );

  assign in_exec = (phase_i == PH_EXEC);
  assign wraps   = &mem_word_i;
  assign stb_d   = in_exec ? op_hit : '0;
  assign ill_d   = in_exec && bad_pat;
  assign skip_d  = in_exec && ((op_hit[OP_ISZ] && wraps) ||
                               (op_hit[OP_ASZ] && acc_zero_i));
  assign imm_d   = (in_exec && op_hit[OP_LAW]) ? imm_raw : '0;

  mrd_out_reg #(.WORD_W(WORD_W)) u_oreg (
    .clk    (clk),
    .rst    (rst),
    .stb_d  (stb_d),
    .inc_d  (inc_d),
    .skip_d (skip_d),
    .ill_d  (ill_d),
    .imm_d  (imm_d),
    .stb_q  (exec_stb_o),
    .inc_q  (mb_inc_req_o),
    .skip_q (skip_o),
    .ill_q  (illegal_o),
    .imm_q  (imm_o)
  );

endmodule

// File: rtl/mrd_chk.sv
module mrd_chk
  import mrd_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int AUTO_BASE  = 8,
  parameter int AUTO_COUNT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] instr_i,
  input logic [1:0]        phase_i,
  input logic [WORD_W-1:0] ptr_addr_i,
  input logic [NOPS-1:0]   exec_stb_o,
  input logic              mb_inc_req_o,
  input logic              skip_o,
  input logic              illegal_o,
  input logic [WORD_W-1:0] imm_o
);
  logic [2:0] mj;
  logic       win;
  logic       mref;

  assign mj   = instr_i[WORD_W-2:WORD_W-4];
  assign mref = (mj == 3'd1) || (mj == 3'd2) || (mj == 3'd3) ||
                (mj == 3'd6) || (mj == 3'd7);
  assign win  = (ptr_addr_i >= WORD_W'(AUTO_BASE)) &&
                (ptr_addr_i < WORD_W'(AUTO_BASE + AUTO_COUNT));

  // R5
  stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(exec_stb_o));

  // R5
  stb_exec_only_chk: assert property (@(posedge clk) disable iff (rst)
    (|exec_stb_o) |-> ($past(phase_i) == PH_EXEC));

  // R4
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (exec_stb_o == '0 && $past(phase_i) == PH_EXEC));

  // R8
  inc_source_chk: assert property (@(posedge clk) disable iff (rst)
    mb_inc_req_o |-> (($past(phase_i) == PH_EXEC && $past(mj) == 3'd3) ||
                      ($past(phase_i) == PH_DEFER && $past(mref) &&
                       $past(instr_i[WORD_W-1]) && $past(win))));

  // R6
  isz_inc_chk: assert property (@(posedge clk) disable iff (rst)
    exec_stb_o[OP_ISZ] |-> mb_inc_req_o);

  // R9
  skip_cause_chk: assert property (@(posedge clk) disable iff (rst)
    skip_o |-> (exec_stb_o[OP_ISZ] || exec_stb_o[OP_ASZ]));

  // R3
  imm_law_chk: assert property (@(posedge clk) disable iff (rst)
    (imm_o != '0) |-> exec_stb_o[OP_LAW]);

  // R11
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (exec_stb_o == '0 && !mb_inc_req_o && !skip_o &&
                    !illegal_o && imm_o == '0));

endmodule

bind mrd_decode mrd_chk #(
  .WORD_W     (WORD_W),
  .AUTO_BASE  (AUTO_BASE),
  .AUTO_COUNT (AUTO_COUNT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .instr_i      (instr_i),
  .phase_i      (phase_i),
  .ptr_addr_i   (ptr_addr_i),
  .exec_stb_o   (exec_stb_o),
  .mb_inc_req_o (mb_inc_req_o),
  .skip_o       (skip_o),
  .illegal_o    (illegal_o),
  .imm_o        (imm_o)
);

// File: tb/mrd_decode_tb.sv
module mrd_decode_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = '0;
  logic [1:0]  phase = '0;
  logic [15:0] ptr = '0;
  logic [15:0] memw = '0;
  logic        accz = 1'b0;
  logic [9:0]  stb;
  logic        inc;
  logic        skp;
  logic        ill;
  logic [15:0] imm;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  mrd_decode u_dut (
    .clk          (clk),
    .rst          (rst),
    .instr_i      (instr),
    .phase_i      (phase),
    .ptr_addr_i   (ptr),
    .mem_word_i   (memw),
    .acc_zero_i   (accz),
    .exec_stb_o   (stb),
    .mb_inc_req_o (inc),
    .skip_o       (skip_o_w),
    .illegal_o    (ill),
    .imm_o        (imm)
  );

  logic skip_o_w;
  assign skp = skip_o_w;

  function automatic void model(input logic [15:0] w, input logic [1:0] ph,
                                input logic [15:0] p, input logic [15:0] m,
                                input logic az, output logic [9:0] s,
                                output logic i, output logic k,
                                output logic b, output logic [15:0] v);
    logic [2:0] mj;
    logic       mr;
    int         idx;
    mj  = w[14:12];
    mr  = (mj == 1) || (mj == 2) || (mj == 3) || (mj == 6) || (mj == 7);
    idx = -1;
    if      (mj == 1) idx = 4;
    else if (mj == 2) idx = 1;
    else if (mj == 3) idx = 5;
    else if (mj == 7) idx = 3;
    else if (mj == 6) idx = w[11] ? 2 : 0;
    else if (w[15:11] == 5'b00001) idx = 6;
    else if (w == 16'o000000) idx = 8;
    else if (w == 16'o002001) idx = 7;
    else if (w == 16'o100011) idx = 9;
    s = '0; b = 1'b0; v = '0; k = 1'b0;
    if (ph == 2) begin
      if (idx < 0) b = 1'b1;
      else s[idx] = 1'b1;
      if (idx == 6) v = {5'b0, w[10:0]};
      k = (idx == 5 && m == 16'hFFFF) || (idx == 7 && az);
    end
    i = (ph == 2 && mj == 3) || (ph == 1 && mr && w[15] && p >= 8 && p <= 15);
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic [15:0] w, input logic [1:0] ph,
                     input logic [15:0] p, input logic [15:0] m, input logic az);
    logic [9:0] es; logic ei, ek, eb; logic [15:0] ev;
    instr = w; phase = ph; ptr = p; memw = m; accz = az;
    @(negedge clk);
    model(w, ph, p, m, az, es, ei, ek, eb, ev);
    cmp({tag, " strobe"},  32'(stb), 32'(es));
    cmp({tag, " inc"},     32'(inc), 32'(ei));
    cmp({tag, " skip"},    32'(skp), 32'(ek));
    cmp({tag, " illegal"}, 32'(ill), 32'(eb));
    cmp({tag, " imm"},     32'(imm), 32'(ev));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R11: reset held while an increment-and-skip execute is presented
    instr = 16'o030030; phase = 2; memw = 16'hFFFF; ptr = 16'o10;
    repeat (3) @(negedge clk);
    cmp("R11 reset strobe", 32'(stb), 0);
    cmp("R11 reset inc", 32'(inc), 0);
    cmp("R11 reset skip", 32'(skp), 0);
    rst = 1'b0;

    // R1 memory-reference operations, direct and indirect
    run("R1 jmp",      16'o010002, 2, 0, 0, 0);
    run("R1 jmp b11",  16'o014002, 2, 0, 0, 0);
    run("R1 dac",      16'o020030, 2, 0, 0, 0);
    run("R1 isz",      16'o030031, 2, 0, 0, 0);
    run("R1 lac",      16'o060031, 2, 0, 0, 0);
    run("R1 add",      16'o064003, 2, 0, 0, 0);
    run("R1 sub",      16'o070031, 2, 0, 0, 0);
    run("R1 lac ind",  16'o160030, 2, 0, 0, 0);
    // R2 exact operate words
    run("R2 hlt",      16'o000000, 2, 0, 0, 0);
    run("R2 asz",      16'o002001, 2, 0, 0, 0);
    run("R2 cal",      16'o100011, 2, 0, 0, 0);
    // R3 load immediate
    run("R3 law",      16'o004100, 2, 0, 0, 0);
    run("R3 law max",  16'o007777, 2, 0, 0, 0);
    // R4 illegal patterns
    run("R4 maj4",     16'o040000, 2, 0, 0, 0);
    run("R4 maj5",     16'o050123, 2, 0, 0, 0);
    run("R4 law ind",  16'o104100, 2, 0, 0, 0);
    run("R4 op0 odd",  16'o000001, 2, 0, 0, 0);
    run("R4 fetch",    16'o040000, 0, 0, 0, 0);
    // R5 no strobe outside execute
    run("R5 fetch isz", 16'o030030, 0, 16'o10, 16'hFFFF, 1);
    run("R5 idle lac",  16'o060031, 3, 0, 0, 0);
    // R6 increment from execute of increment-and-skip
    run("R6 isz exec",  16'o030030, 2, 16'o100, 16'h0005, 0);
    run("R6 isz ind",   16'o130030, 2, 16'o100, 16'h0005, 0);
    // R7 auto-increment window edges
    run("R7 ptr 10",    16'o160010, 1, 16'o10, 0, 0);
    run("R7 ptr 17",    16'o120017, 1, 16'o17, 0, 0);
    run("R7 jmp ind",   16'o110012, 1, 16'o12, 0, 0);
    // R8 no stray increment
    run("R8 ptr 7",     16'o160007, 1, 16'o7, 0, 0);
    run("R8 ptr 20",    16'o160020, 1, 16'o20, 0, 0);
    run("R8 direct def",16'o060010, 1, 16'o10, 0, 0);
    run("R8 dac exec",  16'o120030, 2, 16'o10, 0, 0);
    run("R8 lac exec",  16'o060031, 2, 16'o10, 0, 0);
    run("R8 cal defer", 16'o100011, 1, 16'o10, 0, 0);
    run("R8 isz defer", 16'o030030, 1, 16'o40, 0, 0);
    run("R8 high ptr",  16'o160010, 1, 16'o100010, 0, 0);
    // R9 wrap skip
    run("R9 wrap",      16'o030031, 2, 0, 16'hFFFF, 0);
    run("R9 nowrap",    16'o030031, 2, 0, 16'hFFFE, 1);
    // R10 accumulator-zero skip
    run("R10 az",       16'o002001, 2, 0, 16'hFFFF, 1);
    run("R10 anz",      16'o002001, 2, 0, 16'hFFFF, 0);
    run("R10 other",    16'o060031, 2, 0, 16'hFFFF, 1);

    // R1..R10 mixed random traffic
    for (int it = 0; it < 3000; it++) begin
      logic [15:0] w, p, m;
      int sel;
      sel = $urandom % 6;
      w = 16'($urandom);
      case (sel)
        0: w[14:12] = 3'd3;
        1: w = (($urandom % 2) != 0) ? 16'o002001 : 16'o100011;
        2: w[14:11] = 4'b0001;
        3: w[14:12] = 3'd6;
        default: ;
      endcase
      p = (($urandom % 2) != 0) ? 16'($urandom % 32) : 16'($urandom);
      m = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
      run("R8 random", w, 2'($urandom), p, m, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

endmodule